// File: doc/BRIEF.md
# Receive Message Buffer Allocator

This block sits behind the acceptance stage of a CAN controller's message object RAM. Each cycle that a frame arrives, it picks which receive object stores it. Every object holds its own configuration: valid, direction, identifier, acceptance mask, use-mask, receive-interrupt enable and end-of-buffer. For each object it also keeps the stored frame and three status flags: new-data, interrupt-pending and message-lost.

The block treats the objects as chained FIFOs. A run of receive objects with the same filter fills from the lowest number upward. An object whose new-data flag is set counts as occupied and is skipped. The object that carries end-of-buffer closes the chain. If a frame reaches that object while it is still occupied, the frame overwrites it and the loss is recorded. The block also produces an interrupt identifier. A status event takes precedence over all else. Otherwise the identifier names the lowest-numbered object with an interrupt pending.

Object configuration, flag clearing and stored-frame reads go through simple side ports. All object indices on the ports are zero-based. The interrupt identifier reports the object number, which is the index plus one.

Top module: `rx_slot_allocator`

## Requirements
- R1: After reset, the new-data, interrupt-pending and message-lost vectors are all zero, the interrupt identifier is 0, and neither store_valid nor store_drop is asserted.
- R2: An accepted frame is written into the lowest-indexed matching object whose new-data bit is clear. Its new-data bit is set at the clock edge that samples frm_valid. One cycle later store_valid pulses with store_idx equal to that index.
- R3: An object takes part in allocation only when it is valid and configured for receive. An invalid object or a transmit object never receives a frame, even when its filter would match.
- R4: A frame matches an object only when the extended flags are equal. The identifier comparison is then exact over all 29 bits when use-mask is 0. When use-mask is 1, only the bit positions where the object's mask bit is 1 are compared.
- R5: A matching object whose new-data bit is set and that has no end-of-buffer is skipped, and the scan continues to higher indices.
- R6: When the scan reaches a matching end-of-buffer object whose new-data bit is set, the frame overwrites it. That object's message-lost bit is set and store_lost is 1 with the store_valid pulse.
- R7: A frame for which no object qualifies produces a store_drop pulse one cycle later and leaves all flag vectors unchanged.
- R8: Storing a frame sets the object's interrupt-pending bit only if that object's receive-interrupt enable is 1. New-data is set either way.
- R9: int_id is 16'h8000 while stat_irq is high. Otherwise it is the object number (index plus one) of the lowest-indexed set interrupt-pending bit, or 0 when none is set.
- R10: A clear request for one object clears only the flags it selects: new-data, interrupt-pending and/or message-lost. Other flags and other objects are left unchanged. An object whose new-data bit is cleared becomes free again.
- R11: A configuration write replaces the object's configuration and clears its new-data, interrupt-pending and message-lost bits. A frame that would land in that same object in that same cycle is dropped instead.
- R12: The read port returns, combinationally for rd_idx, the identifier, extended flag, data length code and data of the last frame stored in that object.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write configuration of object cfg_idx |
| cfg_idx | input | IDX_W | Object index for configuration |
| cfg_valid | input | 1 | Object takes part in traffic |
| cfg_tx | input | 1 | Object is a transmit object |
| cfg_umask | input | 1 | Apply the acceptance mask |
| cfg_rxie | input | 1 | Receive interrupt enable |
| cfg_eob | input | 1 | End-of-buffer: last object of a FIFO chain |
| cfg_xtd | input | 1 | Object expects extended identifiers |
| cfg_id | input | 29 | Object identifier |
| cfg_mask | input | 29 | Acceptance mask, 1 = compare bit |
| frm_valid | input | 1 | Accepted frame present this cycle |
| frm_xtd | input | 1 | Frame uses an extended identifier |
| frm_id | input | 29 | Frame identifier |
| frm_dlc | input | DLC_W | Frame data length code |
| frm_data | input | DATA_W | Frame data bytes |
| clr_valid | input | 1 | Clear flags of object clr_idx |
| clr_idx | input | IDX_W | Object index for clearing |
| clr_newdat | input | 1 | Clear new-data |
| clr_intpnd | input | 1 | Clear interrupt-pending |
| clr_msglost | input | 1 | Clear message-lost |
| stat_irq | input | 1 | Status interrupt pending |
| rd_idx | input | IDX_W | Object index for reading stored frame |
| rd_id | output | 29 | Stored identifier |
| rd_xtd | output | 1 | Stored extended flag |
| rd_dlc | output | DLC_W | Stored data length code |
| rd_data | output | DATA_W | Stored data |
| store_valid | output | 1 | Previous cycle's frame was stored |
| store_idx | output | IDX_W | Index of the object that stored it |
| store_lost | output | 1 | The store overwrote unread data |
| store_drop | output | 1 | Previous cycle's frame found no object |
| newdat_vec | output | NUM_OBJ | New-data bit per object, bit i = index i |
| intpnd_vec | output | NUM_OBJ | Interrupt-pending bit per object |
| msglost_vec | output | NUM_OBJ | Message-lost bit per object |
| int_id | output | 16 | Highest-priority interrupt source |

## Verification
The assertions assume the side ports are used one at a time per object: a clear request and a frame store aimed at the same object in the same cycle are resolved in favour of the store. They also assume stat_irq is a plain level. The stimulus drives configuration, frames and clears in separate cycles, always at the falling edge. It takes no frame into the same cycle as a configuration write, so each store or drop is attributable to one frame. Filters are chosen so that every frame meets exactly one intended outcome: a free slot, a skipped slot, an end-of-chain overwrite, or no candidate.

// File: rtl/rx_alloc_pkg.sv
package rx_alloc_pkg;

  localparam int ID_W     = 29;
  localparam int INT_ID_W = 16;
  localparam logic [INT_ID_W-1:0] STATUS_SRC = 16'h8000;

  typedef struct packed {
    logic            valid;
    logic            is_tx;
    logic            use_mask;
    logic            rx_ie;
    logic            eob;
    logic            xtd;
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] mask;
  } obj_cfg_t;

endpackage

// File: rtl/rxa_prio_pick.sv
module rxa_prio_pick #(
  parameter  int N     = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  // lowest set bit wins
  assign onehot = req & (~req + N'(1));
  assign any    = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/rxa_accept_filter.sv
module rxa_accept_filter
  import rx_alloc_pkg::*;
#(
  parameter int NUM_OBJ = 32
) (
  input  obj_cfg_t           cfg_q [NUM_OBJ],
  input  logic               frm_xtd,
  input  logic [ID_W-1:0]    frm_id,
  output logic [NUM_OBJ-1:0] match
);

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cmp
    logic [ID_W-1:0] cmp_bits;
    logic            id_eq;

    assign cmp_bits = cfg_q[g].use_mask ? cfg_q[g].mask : {ID_W{1'b1}};
    assign id_eq    = ((frm_id ^ cfg_q[g].id) & cmp_bits) == '0;
    assign match[g] = cfg_q[g].valid && !cfg_q[g].is_tx &&
                      (cfg_q[g].xtd == frm_xtd) && id_eq;
  end

endmodule

// File: rtl/rxa_obj_store.sv
module rxa_obj_store
  import rx_alloc_pkg::*;
#(
  parameter  int NUM_OBJ = 32,
  parameter  int DATA_W  = 64,
  parameter  int DLC_W   = 4,
  localparam int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  obj_cfg_t           cfg_in,
  input  logic [NUM_OBJ-1:0] wr_sel,
  input  logic               wr_ovw,
  input  logic               frm_xtd,
  input  logic [ID_W-1:0]    frm_id,
  input  logic [DLC_W-1:0]   frm_dlc,
  input  logic [DATA_W-1:0]  frm_data,
  input  logic               clr_valid,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               clr_newdat,
  input  logic               clr_intpnd,
  input  logic               clr_msglost,
  input  logic [IDX_W-1:0]   rd_idx,
  output obj_cfg_t           cfg_q [NUM_OBJ],
  output logic [NUM_OBJ-1:0] newdat_vec,
  output logic [NUM_OBJ-1:0] intpnd_vec,
  output logic [NUM_OBJ-1:0] msglost_vec,
  output logic [ID_W-1:0]    rd_id,
  output logic               rd_xtd,
  output logic [DLC_W-1:0]   rd_dlc,
  output logic [DATA_W-1:0]  rd_data
);

  logic [ID_W-1:0]   pid_arr  [NUM_OBJ];
  logic              pxtd_arr [NUM_OBJ];
  logic [DLC_W-1:0]  pdlc_arr [NUM_OBJ];
  logic [DATA_W-1:0] pdat_arr [NUM_OBJ];

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    obj_cfg_t          cfg_r, cfg_n;
    logic              nd_r, nd_n, ip_r, ip_n, ml_r, ml_n;
    logic              cfg_hit, clr_hit, pl_en;
    logic [ID_W-1:0]   pid_r;
    logic              pxtd_r;
    logic [DLC_W-1:0]  pdlc_r;
    logic [DATA_W-1:0] pdat_r;

    assign cfg_hit = cfg_we && (cfg_idx == IDX_W'(g));
    assign clr_hit = clr_valid && (clr_idx == IDX_W'(g));

    // priority: configuration write, then frame store, then clear
    always_comb begin
      cfg_n = cfg_r;
      nd_n  = nd_r;
      ip_n  = ip_r;
      ml_n  = ml_r;
      pl_en = 1'b0;
      if (cfg_hit) begin
        cfg_n = cfg_in;
        nd_n  = 1'b0;
        ip_n  = 1'b0;
        ml_n  = 1'b0;
      end else if (wr_sel[g]) begin
        nd_n  = 1'b1;
        ip_n  = ip_r | cfg_r.rx_ie;
        ml_n  = ml_r | wr_ovw;
        pl_en = 1'b1;
      end else if (clr_hit) begin
        if (clr_newdat)  nd_n = 1'b0;
        if (clr_intpnd)  ip_n = 1'b0;
        if (clr_msglost) ml_n = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_r <= '0;
        nd_r  <= 1'b0;
        ip_r  <= 1'b0;
        ml_r  <= 1'b0;
      end else begin
        cfg_r <= cfg_n;
        nd_r  <= nd_n;
        ip_r  <= ip_n;
        ml_r  <= ml_n;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pid_r  <= '0;
        pxtd_r <= 1'b0;
        pdlc_r <= '0;
        pdat_r <= '0;
      end else if (pl_en) begin
        pid_r  <= frm_id;
        pxtd_r <= frm_xtd;
        pdlc_r <= frm_dlc;
        pdat_r <= frm_data;
      end
    end

    assign cfg_q[g]       = cfg_r;
    assign newdat_vec[g]  = nd_r;
    assign intpnd_vec[g]  = ip_r;
    assign msglost_vec[g] = ml_r;
    assign pid_arr[g]     = pid_r;
    assign pxtd_arr[g]    = pxtd_r;
    assign pdlc_arr[g]    = pdlc_r;
    assign pdat_arr[g]    = pdat_r;

    // R11: a configuration write leaves the object empty
    a_r11_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |=> (!nd_r && !ip_r && !ml_r));
  end

  always_comb begin
    rd_id   = '0;
    rd_xtd  = 1'b0;
    rd_dlc  = '0;
    rd_data = '0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_id   = pid_arr[i];
        rd_xtd  = pxtd_arr[i];
        rd_dlc  = pdlc_arr[i];
        rd_data = pdat_arr[i];
      end
    end
  end

endmodule

// File: rtl/rx_slot_allocator.sv
module rx_slot_allocator
  import rx_alloc_pkg::*;
#(
  parameter  int NUM_OBJ = 32,
  parameter  int DATA_W  = 64,
  parameter  int DLC_W   = 4,
  localparam int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic                cfg_valid,
  input  logic                cfg_tx,
  input  logic                cfg_umask,
  input  logic                cfg_rxie,
  input  logic                cfg_eob,
  input  logic                cfg_xtd,
  input  logic [ID_W-1:0]     cfg_id,
  input  logic [ID_W-1:0]     cfg_mask,
  input  logic                frm_valid,
  input  logic                frm_xtd,
  input  logic [ID_W-1:0]     frm_id,
  input  logic [DLC_W-1:0]    frm_dlc,
  input  logic [DATA_W-1:0]   frm_data,
  input  logic                clr_valid,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic                clr_newdat,
  input  logic                clr_intpnd,
  input  logic                clr_msglost,
  input  logic                stat_irq,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [ID_W-1:0]     rd_id,
  output logic                rd_xtd,
  output logic [DLC_W-1:0]    rd_dlc,
  output logic [DATA_W-1:0]   rd_data,
  output logic                store_valid,
  output logic [IDX_W-1:0]    store_idx,
  output logic                store_lost,
  output logic                store_drop,
  output logic [NUM_OBJ-1:0]  newdat_vec,
  output logic [NUM_OBJ-1:0]  intpnd_vec,
  output logic [NUM_OBJ-1:0]  msglost_vec,
  output logic [INT_ID_W-1:0] int_id
);

  obj_cfg_t           cfg_in;
  obj_cfg_t           cfg_q [NUM_OBJ];
  logic [NUM_OBJ-1:0] match, eob_vec, rxie_vec, cand_free, cand_end, hit;
  logic [NUM_OBJ-1:0] pick_oh, irq_oh, wr_sel;
  logic [IDX_W-1:0]   pick_idx, irq_idx;
  logic               pick_any, irq_any, pick_ovw, cfg_block, accept;

  logic               sv_n, sv_r, sl_n, sl_r, sd_n, sd_r;
  logic [IDX_W-1:0]   si_n, si_r;

  assign cfg_in = '{valid: cfg_valid, is_tx: cfg_tx, use_mask: cfg_umask,
                    rx_ie: cfg_rxie, eob: cfg_eob, xtd: cfg_xtd,
                    id: cfg_id, mask: cfg_mask};

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_attr
    assign eob_vec[g]  = cfg_q[g].eob;
    assign rxie_vec[g] = cfg_q[g].rx_ie;
  end

  rxa_accept_filter #(.NUM_OBJ(NUM_OBJ)) u_filter (
    .cfg_q   (cfg_q),
    .frm_xtd (frm_xtd),
    .frm_id  (frm_id),
    .match   (match)
  );

  // free slots qualify; an occupied slot qualifies only as a chain end
  assign cand_free = match & ~newdat_vec;
  assign cand_end  = match & newdat_vec & eob_vec;
  assign hit       = cand_free | cand_end;

  rxa_prio_pick #(.N(NUM_OBJ)) u_alloc (
    .req    (hit),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  assign pick_ovw  = |(pick_oh & cand_end);
  assign cfg_block = cfg_we && (cfg_idx == pick_idx);
  assign accept    = frm_valid && pick_any && !cfg_block;
  assign wr_sel    = accept ? pick_oh : '0;

  rxa_obj_store #(.NUM_OBJ(NUM_OBJ), .DATA_W(DATA_W), .DLC_W(DLC_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_in      (cfg_in),
    .wr_sel      (wr_sel),
    .wr_ovw      (pick_ovw),
    .frm_xtd     (frm_xtd),
    .frm_id      (frm_id),
    .frm_dlc     (frm_dlc),
    .frm_data    (frm_data),
    .clr_valid   (clr_valid),
    .clr_idx     (clr_idx),
    .clr_newdat  (clr_newdat),
    .clr_intpnd  (clr_intpnd),
    .clr_msglost (clr_msglost),
    .rd_idx      (rd_idx),
    .cfg_q       (cfg_q),
    .newdat_vec  (newdat_vec),
    .intpnd_vec  (intpnd_vec),
    .msglost_vec (msglost_vec),
    .rd_id       (rd_id),
    .rd_xtd      (rd_xtd),
    .rd_dlc      (rd_dlc),
    .rd_data     (rd_data)
  );

  // result report, one cycle after the frame
  always_comb begin
    sv_n = accept;
    si_n = accept ? pick_idx : si_r;
    sl_n = accept && pick_ovw;
    sd_n = frm_valid && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_r <= 1'b0;
      si_r <= '0;
      sl_r <= 1'b0;
      sd_r <= 1'b0;
    end else begin
      sv_r <= sv_n;
      si_r <= si_n;
      sl_r <= sl_n;
      sd_r <= sd_n;
    end
  end

  assign store_valid = sv_r;
  assign store_idx   = si_r;
  assign store_lost  = sl_r;
  assign store_drop  = sd_r;

  // interrupt source: status first, then lowest pending object
  rxa_prio_pick #(.N(NUM_OBJ)) u_irq (
    .req    (intpnd_vec),
    .onehot (irq_oh),
    .idx    (irq_idx),
    .any    (irq_any)
  );

  always_comb begin
    if (stat_irq)     int_id = STATUS_SRC;
    else if (irq_any) int_id = INT_ID_W'(irq_idx) + INT_ID_W'(1);
    else              int_id = '0;
  end

  // R2: an accepted frame marks its object as holding new data
  a_r2_store_marks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (store_valid && newdat_vec[store_idx]));

  // R3: only valid receive objects are ever written
  a_r3_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (cfg_q[pick_idx].valid && !cfg_q[pick_idx].is_tx));

  // R6: an overwrite only happens on an occupied chain end
  a_r6_lost_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pick_ovw) |-> (eob_vec[pick_idx] && newdat_vec[pick_idx]));

  // R7: a frame with no slot changes no flag
  a_r7_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !pick_any && !clr_valid && !cfg_we) |=>
      (store_drop && $stable(newdat_vec) && $stable(msglost_vec)));

  // R8: no pending bit without its receive interrupt enable
  a_r8_pend_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (intpnd_vec & ~rxie_vec) == '0);

  // R9: a reported object number always has its pending bit set
  a_r9_id_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id != '0 && int_id != STATUS_SRC) |->
      intpnd_vec[IDX_W'(int_id - INT_ID_W'(1))]);

endmodule

// File: tb/test_rx_slot_allocator.sv
module test_rx_slot_allocator;
  localparam int CLK_PERIOD = 10;
  localparam int NOBJ = 32;
  localparam int IW   = 5;

  typedef struct {
    bit drop;
    int idx;
    bit lost;
    string req;
  } exp_t;

  logic clk, rst_n;
  logic cfg_we, cfg_valid, cfg_tx, cfg_umask, cfg_rxie, cfg_eob, cfg_xtd;
  logic [IW-1:0] cfg_idx, clr_idx, rd_idx, store_idx;
  logic [28:0] cfg_id, cfg_mask, frm_id, rd_id;
  logic frm_valid, frm_xtd, clr_valid, clr_newdat, clr_intpnd, clr_msglost;
  logic stat_irq, rd_xtd, store_valid, store_lost, store_drop;
  logic [3:0] frm_dlc, rd_dlc;
  logic [63:0] frm_data, rd_data;
  logic [NOBJ-1:0] newdat_vec, intpnd_vec, msglost_vec;
  logic [15:0] int_id;

  int n_tests = 0;
  int n_fail  = 0;
  exp_t sb[$];

  rx_slot_allocator i_rx_slot_allocator (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_tx(cfg_tx),
    .cfg_umask(cfg_umask), .cfg_rxie(cfg_rxie), .cfg_eob(cfg_eob), .cfg_xtd(cfg_xtd),
    .cfg_id(cfg_id), .cfg_mask(cfg_mask),
    .frm_valid(frm_valid), .frm_xtd(frm_xtd), .frm_id(frm_id), .frm_dlc(frm_dlc),
    .frm_data(frm_data),
    .clr_valid(clr_valid), .clr_idx(clr_idx), .clr_newdat(clr_newdat),
    .clr_intpnd(clr_intpnd), .clr_msglost(clr_msglost),
    .stat_irq(stat_irq), .rd_idx(rd_idx),
    .rd_id(rd_id), .rd_xtd(rd_xtd), .rd_dlc(rd_dlc), .rd_data(rd_data),
    .store_valid(store_valid), .store_idx(store_idx), .store_lost(store_lost),
    .store_drop(store_drop),
    .newdat_vec(newdat_vec), .intpnd_vec(intpnd_vec), .msglost_vec(msglost_vec),
    .int_id(int_id)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (store_valid || store_drop)) begin
      if (sb.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R2 unexpected result: actual valid=%0b drop=%0b expected none",
                 store_valid, store_drop);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.req, "drop flag", 64'(store_drop), 64'(e.drop));
        if (!e.drop) begin
          chk(e.req, "store index", 64'(store_idx), 64'(e.idx));
          chk(e.req, "lost flag", 64'(store_lost), 64'(e.lost));
        end
      end
    end
  end

  task automatic cfg_obj(input int idx, input bit v, input bit tx, input bit um,
                         input bit ie, input bit eob, input bit x,
                         input logic [28:0] id, input logic [28:0] mk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_valid = v; cfg_tx = tx; cfg_umask = um;
    cfg_rxie = ie; cfg_eob = eob; cfg_xtd = x; cfg_id = id; cfg_mask = mk;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input bit x, input logic [28:0] id, input logic [63:0] d,
                      input bit drop, input int idx, input bit lost, input string req);
    exp_t e;
    e.drop = drop; e.idx = idx; e.lost = lost; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    frm_valid = 1'b1; frm_xtd = x; frm_id = id; frm_dlc = 4'd8; frm_data = d;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic clr(input int idx, input bit nd, input bit ip, input bit ml);
    @(negedge clk);
    clr_valid = 1'b1; clr_idx = IW'(idx);
    clr_newdat = nd; clr_intpnd = ip; clr_msglost = ml;
    @(negedge clk);
    clr_valid = 1'b0;
  endtask

  task automatic vecs(input string req, input logic [31:0] nd,
                      input logic [31:0] ip, input logic [31:0] ml);
    chk(req, "newdat_vec", 64'(newdat_vec), 64'(nd));
    chk(req, "intpnd_vec", 64'(intpnd_vec), 64'(ip));
    chk(req, "msglost_vec", 64'(msglost_vec), 64'(ml));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_idx = 0; cfg_valid = 0; cfg_tx = 0; cfg_umask = 0; cfg_rxie = 0;
    cfg_eob = 0; cfg_xtd = 0; cfg_id = 0; cfg_mask = 0;
    frm_valid = 0; frm_xtd = 0; frm_id = 0; frm_dlc = 0; frm_data = 0;
    clr_valid = 0; clr_idx = 0; clr_newdat = 0; clr_intpnd = 0; clr_msglost = 0;
    stat_irq = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    vecs("R1", 32'h0, 32'h0, 32'h0);
    chk("R1", "int_id", 64'(int_id), 64'h0);
    chk("R1", "store_valid", 64'(store_valid), 64'h0);
    chk("R1", "store_drop", 64'(store_drop), 64'h0);

    // receive FIFO of four standard objects, accept-all mask, end on index 3
    for (int i = 0; i < 4; i++) cfg_obj(i, 1, 0, 1, 1, (i == 3), 0, 29'h0, 29'h0);
    cfg_obj(4, 1, 0, 0, 0, 1, 1, 29'h1234567, 29'h0);        // exact, no irq
    cfg_obj(5, 1, 1, 1, 1, 1, 0, 29'h0, 29'h0);               // transmit
    cfg_obj(6, 0, 0, 1, 1, 1, 1, 29'h0, 29'h0);               // invalid
    cfg_obj(7, 1, 0, 1, 1, 1, 1, 29'h0ABCDE00, 29'h1FFFFF00); // masked extended

    // R2 first frame to lowest free object
    send(0, 29'h123, 64'h1111_2222_3333_4444, 0, 0, 0, "R2");
    vecs("R2", 32'h1, 32'h1, 32'h0);
    chk("R9", "int_id lowest", 64'(int_id), 64'd1);
    rd_idx = 0; #1;
    chk("R12", "rd_id", 64'(rd_id), 64'h123);
    chk("R12", "rd_xtd", 64'(rd_xtd), 64'h0);
    chk("R12", "rd_dlc", 64'(rd_dlc), 64'h8);
    chk("R12", "rd_data", rd_data, 64'h1111_2222_3333_4444);

    // R5 occupied non-final objects are skipped
    send(0, 29'h124, 64'hB, 0, 1, 0, "R5");
    send(0, 29'h125, 64'hC, 0, 2, 0, "R5");
    send(0, 29'h126, 64'hD, 0, 3, 0, "R5");
    vecs("R5", 32'hF, 32'hF, 32'h0);

    // R6 overwrite at occupied end of chain
    send(0, 29'h127, 64'hEEEE, 0, 3, 1, "R6");
    vecs("R6", 32'hF, 32'hF, 32'h8);
    rd_idx = 3; #1;
    chk("R6", "overwritten data", rd_data, 64'hEEEE);

    // R4 exact match, R8 no pending bit without enable
    send(1, 29'h1234567, 64'h44, 0, 4, 0, "R4");
    vecs("R8", 32'h1F, 32'h0F, 32'h8);

    // R4/R7 one identifier bit off: no object qualifies
    send(1, 29'h1234568, 64'h55, 1, 0, 0, "R7");
    vecs("R7", 32'h1F, 32'h0F, 32'h8);

    // R4 masked match ignores low byte
    send(1, 29'h0ABCDE5A, 64'h77, 0, 7, 0, "R4");
    vecs("R4", 32'h9F, 32'h8F, 32'h8);
    rd_idx = 7; #1;
    chk("R12", "rd_id ext", 64'(rd_id), 64'h0ABCDE5A);
    chk("R12", "rd_xtd ext", 64'(rd_xtd), 64'h1);

    // R9 status has precedence
    @(negedge clk); stat_irq = 1'b1; #1;
    chk("R9", "status id", 64'(int_id), 64'h8000);
    @(negedge clk); stat_irq = 1'b0; #1;
    chk("R9", "back to object", 64'(int_id), 64'd1);

    // R10 selective clear frees object 0
    clr(0, 1, 1, 0);
    vecs("R10", 32'h9E, 32'h8E, 32'h8);
    chk("R10", "int_id after clear", 64'(int_id), 64'd2);
    send(0, 29'h200, 64'hF0, 0, 0, 0, "R10");
    vecs("R10", 32'h9F, 32'h8F, 32'h8);
    clr(3, 0, 0, 1);
    vecs("R10", 32'h9F, 32'h8F, 32'h0);

    // R6 masked end object overwritten
    send(1, 29'h0ABCDE00, 64'h99, 0, 7, 1, "R6");
    vecs("R6", 32'h9F, 32'h8F, 32'h80);

    // R11 reconfiguration empties the object
    cfg_obj(7, 1, 0, 1, 1, 1, 1, 29'h0ABCDE00, 29'h1FFFFF00);
    vecs("R11", 32'h1F, 32'h0F, 32'h0);
    cfg_obj(3, 0, 0, 1, 1, 1, 0, 29'h0, 29'h0);
    vecs("R11", 32'h17, 32'h07, 32'h0);

    // R3 transmit object and invalid object never take frames
    send(0, 29'h300, 64'h1, 1, 0, 0, "R3");
    send(1, 29'h0000001, 64'h2, 1, 0, 0, "R3");
    vecs("R3", 32'h17, 32'h07, 32'h0);

    repeat (3) @(negedge clk);
    chk("R2", "scoreboard drained", 64'(sb.size()), 64'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule